// File: doc/BRIEF.md
# Power Partition Gate Controller

This block brings individually numbered power domains up on request from software. Software uses a small word-addressed register bus to write a partition number together with a start flag. The controller picks up the request one clock later and clears the flag. It then raises that partition's enable output and waits for a programmable settling interval. When the interval ends, it marks the partition as good in a per-partition status word.

The settling interval is a timer value scaled by a power-of-two multiplier. The controller takes a copy of the interval when it picks up a request, so later register writes do not change a ramp that is already running. Only one request runs at a time. A request that names a partition already up, or a number with no partition behind it, is picked up and then dropped. Partitions that are alive when reset is released can be declared by a parameter.

Top module: `pwr_partition_gate`

## Requirements
- R1: After reset the request register, timer register and multiplier register all read 0. The status word and the enable outputs both equal the reset-powered parameter mask.
- R2: The request register sits at word address 0. It holds the partition number in bits 4:0 and the start flag in bit 8, and all other bits read 0. The status word is at address 1, the timer at address 2 and the multiplier at address 3.
- R3: The start flag reads 1 from the clock edge that wrote it until the next rising edge, when the request is picked up. From then on it reads 0.
- R4: When a valid request for an unpowered partition is picked up, that partition's enable output goes high on the same edge.
- R5: The partition's status bit is set D+1 rising edges after the pick-up edge. D is the timer value times 1, 2, 4 or 8 for multiplier codes 0, 1, 2 and 3. Only one status bit can change on any edge.
- R6: A request for a partition whose status bit is already set changes neither the status word nor the enables. The controller is idle again one edge after the write.
- R7: A request whose number is 23 or more changes neither the status word nor the enables.
- R8: A write to the request register while the controller is busy is ignored as a whole. Both the number and the flag keep their values.
- R9: Status bits and enable bits never clear except by reset. Writes to the status address have no effect.
- R10: The timer register keeps its low 20 bits and the multiplier keeps its low 2 bits. D is taken from the values present at pick-up, so a timer write during a ramp does not change that ramp.
- R11: The busy output is high from the edge that writes the start flag until the edge that sets the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwr_en | output | 23 | Enable output for each partition |
| busy | output | 1 | A request is pending or ramping |

## Verification
The bench runs the request path with several scaled delays: zero, a small count times two, and a count times eight. The number of edges until the status bit appears is counted for each one, which separates an off-by-one in the countdown from a wrong scaling. It compares requests that are dropped because the partition is already up with requests dropped because the number is out of range. It also sends writes during a ramp, to the request register and to the timer, to show that busy writes are rejected and that the delay is copied at pick-up. A behavioural model is checked against the read data, enables and busy on every cycle, so timing errors show up in the exact cycle they occur.

// File: rtl/pwr_partition_gate.sv
module pwr_partition_gate #(
  parameter int NUM_PART = 23,
  parameter int ID_W     = 5,
  parameter int TIMER_W  = 20,
  parameter int MULT_W   = 2,
  parameter logic [NUM_PART-1:0] RESET_ON = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [1:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PART-1:0] pwr_en,
  output logic                busy
);
  localparam int DATA_W    = 32;
  localparam int START_BIT = 8;
  localparam int MAX_SHIFT = (1 << MULT_W) - 1;
  localparam int CNT_W     = TIMER_W + MAX_SHIFT;
  localparam logic [1:0] A_REQ = 2'd0, A_STAT = 2'd1, A_TMR = 2'd2, A_MULT = 2'd3;

  logic                start_q, ramp_q;
  logic [ID_W-1:0]     id_q;
  logic [TIMER_W-1:0]  timer_q;
  logic [MULT_W-1:0]   mult_q;
  logic [NUM_PART-1:0] status_q, en_q, cur_q, sel_mask;
  logic [CNT_W-1:0]    cnt_q, delay;
  logic                wr, wr_req;
  logic                unused_wbits;

  assign busy         = start_q | ramp_q;
  assign wr           = bus_en & bus_we;
  assign wr_req       = wr & (bus_addr == A_REQ) & ~busy;
  assign sel_mask     = NUM_PART'(1) << id_q;
  assign delay        = CNT_W'(timer_q) << mult_q;
  assign pwr_en       = en_q;
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      ramp_q   <= 1'b0;
      id_q     <= '0;
      timer_q  <= '0;
      mult_q   <= '0;
      status_q <= RESET_ON;
      en_q     <= RESET_ON;
      cur_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (ramp_q) begin
        if (cnt_q == '0) begin
          status_q <= status_q | cur_q;
          ramp_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_q) begin
        start_q <= 1'b0;
        if ((sel_mask != '0) && ((status_q & sel_mask) == '0)) begin
          en_q   <= en_q | sel_mask;
          cur_q  <= sel_mask;
          cnt_q  <= delay;
          ramp_q <= 1'b1;
        end
      end
      if (wr_req) begin
        id_q    <= bus_wdata[ID_W-1:0];
        start_q <= bus_wdata[START_BIT];
      end
      if (wr && bus_addr == A_TMR)  timer_q <= bus_wdata[TIMER_W-1:0];
      if (wr && bus_addr == A_MULT) mult_q  <= bus_wdata[MULT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REQ: begin
        bus_rdata[ID_W-1:0]  = id_q;
        bus_rdata[START_BIT] = start_q;
      end
      A_STAT:  bus_rdata = DATA_W'(status_q);
      A_TMR:   bus_rdata = DATA_W'(timer_q);
      default: bus_rdata = DATA_W'(mult_q);
    endcase
  end

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_q) & ~status_q) == '0));
  assert_enable_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(en_q) & ~en_q) == '0));
  assert_status_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~en_q) == '0));
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  assert_single_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q & ~$past(status_q)));
  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr && bus_addr == A_REQ) |=> $stable(id_q));
endmodule

// File: tb/pwr_partition_gate_tb.sv
module pwr_partition_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [22:0] pwr_en;
  logic        busy;
  int checks = 0, errors = 0, cycles = 0;

  pwr_partition_gate #(.RESET_ON(23'h000001)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en), .busy(busy));

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_id, m_cur, m_tmr, m_mult, m_rem;
  bit m_start, mbusy;
  logic [22:0] m_stat, m_en;

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = (32'(m_start) << 8) | 32'(m_id);
      2'd1: m_read = 32'(m_stat);
      2'd2: m_read = 32'(m_tmr);
      default: m_read = 32'(m_mult);
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_id = 0; m_cur = 0; m_tmr = 0; m_mult = 0; m_rem = -1; m_start = 0;
      m_stat = 23'h1; m_en = 23'h1;
    end else begin
      mbusy = m_start || (m_rem >= 0);
      if (m_rem >= 0) begin
        if (m_rem == 0) begin m_stat[m_cur] = 1'b1; m_rem = -1; end
        else m_rem--;
      end else if (m_start) begin
        m_start = 0;
        if (m_id < 23 && !m_stat[m_id]) begin
          m_en[m_id] = 1'b1; m_cur = m_id; m_rem = m_tmr * (1 << m_mult);
        end
      end
      if (bus_en && bus_we) begin
        case (bus_addr)
          2'd0: if (!mbusy) begin m_id = int'(bus_wdata[4:0]); m_start = bus_wdata[8]; end
          2'd2: m_tmr = int'(bus_wdata[19:0]);
          2'd3: m_mult = int'(bus_wdata[1:0]);
          default: ;
        endcase
      end
    end
    #1;
    if (rst_n) begin
      chk("R5 model read", bus_rdata, m_read(bus_addr));
      chk("R4 model enables", 32'(pwr_en), 32'(m_en));
      chk("R11 model busy", 32'(busy), 32'(m_start || (m_rem >= 0)));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    bus_addr = a; #0.5;
    chk(tag, bus_rdata, exp);
    bus_addr = 2'd1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic count_delay(input string tag, input int id, input int exp);
    int n = 0;
    bus_addr = 2'd1; #0.5;
    while (!bus_rdata[id] && n < 1000) begin @(negedge clk); n++; end
    chk(tag, 32'(n), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 request reset", 2'd0, 32'h0);
    rd("R1 status reset", 2'd1, 32'h1);
    rd("R1 timer reset", 2'd2, 32'h0);
    rd("R1 mult reset", 2'd3, 32'h0);
    chk("R1 enables reset", 32'(pwr_en), 32'h1);

    wr(2'd2, 32'hFFFF_FFFF); rd("R10 timer width", 2'd2, 32'h000F_FFFF);
    wr(2'd3, 32'h0000_000F); rd("R10 mult width", 2'd3, 32'h3);
    wr(2'd2, 32'd510000);    rd("R10 timer value", 2'd2, 32'd510000);
    wr(2'd2, 32'd3); wr(2'd3, 32'd1);

    wr(2'd0, 32'h0000_010E);
    rd("R2 request layout", 2'd0, 32'h0000_010E);
    chk("R11 busy after write", 32'(busy), 32'h1);
    @(negedge clk);
    rd("R3 start cleared", 2'd0, 32'h0000_000E);
    chk("R4 enable on pickup", 32'(pwr_en), 32'h4001);
    rd("R5 status not yet", 2'd1, 32'h1);
    wr(2'd0, 32'h0000_010F);
    rd("R8 busy write ignored", 2'd0, 32'h0000_000E);
    wait_idle;
    rd("R5 status set", 2'd1, 32'h4001);

    wr(2'd0, 32'h0000_010F);
    count_delay("R5 delay x2", 15, 8);

    wr(2'd0, 32'h0000_0110);
    wr(2'd2, 32'd0);
    wait_idle;
    rd("R10 delay latched", 2'd1, 32'h1C001);

    wr(2'd0, 32'h0000_0100);
    @(negedge clk);
    chk("R6 powered idle", 32'(busy), 32'h0);
    chk("R6 enables same", 32'(pwr_en), 32'h1C001);
    rd("R6 status same", 2'd1, 32'h1C001);

    wr(2'd0, 32'h0000_011B);
    @(negedge clk);
    chk("R7 out of range enables", 32'(pwr_en), 32'h1C001);
    rd("R7 out of range status", 2'd1, 32'h1C001);

    wr(2'd1, 32'hFFFF_FFFF);
    rd("R9 status write ignored", 2'd1, 32'h1C001);

    wr(2'd0, 32'h0000_0101);
    count_delay("R5 delay zero", 1, 2);

    wr(2'd2, 32'd2); wr(2'd3, 32'd3);
    wr(2'd0, 32'h0000_0116);
    count_delay("R5 delay x8", 22, 18);
    wait_idle;
    chk("R9 enables final", 32'(pwr_en), 32'h41C003);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule